// File: doc/BRIEF.md
# Transactional Read/Write Set Conflict Tracker

This block sits beside one core's private cache and follows the line footprint of the hardware transaction that is currently open on that core. Each transactional load marks its line in a read set. Each transactional store marks its line in a write set. The store's data stays in the local cache and is never pushed to memory while the transaction is open. Lines are named by an index from 0 to `NUM_LINES-1`. Bit i of every set vector stands for line i.

When another core commits, its write set is presented on the remote port. If any line in that vector is also in the local read set, the local transaction must abort. On abort the block pulses `abort_o` and drives the lines it had modified on `inval_mask_o`, so the cache can drop them. The core then reruns the transaction from its start by issuing a new begin command. A line read in the same cycle as the remote delivery takes part in that comparison.

When the core ends its transaction without a conflict, the block pulses `commit_o` and drives its own write set on `commit_wset_o` for broadcast to the other cores. After a commit or an abort both sets are empty, and the block waits idle for the next begin.

Top module: `txn_set_tracker`

## Requirements
- R1: After reset, `active_o`, `abort_o` and `commit_o` are 0, and `commit_wset_o` and `inval_mask_o` are all zeros.
- R2: `begin_i` while idle makes `active_o` 1 from the next cycle, with empty read and write sets.
- R3: A write event while active (`wr_valid_i`, `wr_idx_i`) adds bit `wr_idx_i` to the write set. A write in the same cycle as the end command is included in the write set that is sent out.
- R4: While no commit pulse is present, `commit_wset_o` is all zeros, so no speculative write leaves the block before commit.
- R5: A read event while active adds bit `rd_idx_i` to the read set. A `remote_valid_i` cycle whose `remote_wset_i` shares any bit with the read set causes `abort_o` to be 1 in the next cycle.
- R6: A remote write set that overlaps only the local write set, and not the read set, causes no abort.
- R7: A read in the same cycle as a remote delivery is included in the conflict check.
- R8: `abort_o` is a one-cycle pulse. In that cycle `inval_mask_o` equals the write set, including any write made in the conflict cycle, and `active_o` is 0. At all other times `inval_mask_o` is zero. A following `begin_i` starts a fresh retry.
- R9: `end_i` while active, with no conflict in that cycle, gives a one-cycle `commit_o` pulse in the next cycle, with `commit_wset_o` equal to the write set. The block is idle afterwards.
- R10: Both sets are cleared after a commit or an abort. Lines from an earlier transaction cause neither an abort nor an entry in a later write set.
- R11: While idle, read events, write events, `end_i` and remote deliveries have no effect.
- R12: If a conflict and `end_i` occur in the same cycle, the abort wins and there is no commit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| begin_i | input | 1 | Open a transaction (accepted only while idle) |
| end_i | input | 1 | Request commit of the open transaction |
| rd_valid_i | input | 1 | Transactional read event |
| rd_idx_i | input | IDX_W | Line index of the read |
| wr_valid_i | input | 1 | Transactional write event |
| wr_idx_i | input | IDX_W | Line index of the write |
| remote_valid_i | input | 1 | A remote committed write set is delivered this cycle |
| remote_wset_i | input | NUM_LINES | Remote write set, bit i = line i |
| active_o | output | 1 | A transaction is open |
| abort_o | output | 1 | One-cycle abort pulse |
| inval_mask_o | output | NUM_LINES | Lines to invalidate, valid with abort_o |
| commit_o | output | 1 | One-cycle commit pulse |
| commit_wset_o | output | NUM_LINES | Write set to broadcast, valid with commit_o |

## Verification
The bench builds the block with its default of 64 lines and 6-bit indices. This puts both edge lines, 0 and 63, within reach, so they can be touched in read, write and remote vectors. Directed scenarios cover conflicts that hit through the stored read set and through a read in the same cycle, and overlaps that touch only the write set. They also cover a collision between end and abort, stale lines after a commit, and stimulus applied while idle.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } txn_state_e;
endpackage

// File: rtl/txn_line_set.sv
module txn_line_set #(
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 set_en_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_LINES-1:0] bits_o,
  output logic [NUM_LINES-1:0] next_o
);
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] bits_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_dec
    assign hit[g] = set_en_i && (idx_i == IDX_W'(g));
  end

  // set content including this cycle's access
  assign next_o = bits_q | hit;
  assign bits_o = bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bits_q <= '0;
    else if (clr_i) bits_q <= '0;
    else            bits_q <= next_o;
  end
endmodule

// File: rtl/txn_conflict.sv
module txn_conflict #(
  parameter int NUM_LINES = 64
) (
  input  logic                 remote_valid_i,
  input  logic [NUM_LINES-1:0] remote_wset_i,
  input  logic [NUM_LINES-1:0] rset_i,
  output logic                 conflict_o
);
  assign conflict_o = remote_valid_i && |(remote_wset_i & rset_i);
endmodule

// File: rtl/txn_ctrl.sv
module txn_ctrl
  import txn_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic begin_i,
  input  logic end_i,
  input  logic conflict_i,
  output logic active_o,
  output logic begin_fire_o,
  output logic abort_fire_o,
  output logic commit_fire_o,
  output logic clr_o
);
  txn_state_e state_q, state_d;

  assign active_o      = (state_q == ST_ACTIVE);
  assign begin_fire_o  = (state_q == ST_IDLE) && begin_i;
  assign abort_fire_o  = active_o && conflict_i;
  // abort outranks commit
  assign commit_fire_o = active_o && end_i && !conflict_i;
  assign clr_o         = begin_fire_o || abort_fire_o || commit_fire_o;

  always_comb begin
    state_d = state_q;
    if (begin_fire_o)                       state_d = ST_ACTIVE;
    else if (abort_fire_o || commit_fire_o) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker #(
  parameter int NUM_LINES = 64,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 begin_i,
  input  logic                 end_i,
  input  logic                 rd_valid_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  input  logic                 wr_valid_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic                 remote_valid_i,
  input  logic [NUM_LINES-1:0] remote_wset_i,
  output logic                 active_o,
  output logic                 abort_o,
  output logic [NUM_LINES-1:0] inval_mask_o,
  output logic                 commit_o,
  output logic [NUM_LINES-1:0] commit_wset_o
);
  logic active, begin_fire, abort_fire, commit_fire, clr, conflict;
  logic [NUM_LINES-1:0] rset_q, rset_next, wset_q, wset_next;

  txn_line_set #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_rset (
    .clk_i, .rst_ni, .clr_i(clr), .set_en_i(active && rd_valid_i),
    .idx_i(rd_idx_i), .bits_o(rset_q), .next_o(rset_next)
  );

  txn_line_set #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_wset (
    .clk_i, .rst_ni, .clr_i(clr), .set_en_i(active && wr_valid_i),
    .idx_i(wr_idx_i), .bits_o(wset_q), .next_o(wset_next)
  );

  // same-cycle read takes part in the check
  txn_conflict #(.NUM_LINES(NUM_LINES)) u_conf (
    .remote_valid_i, .remote_wset_i, .rset_i(rset_next), .conflict_o(conflict)
  );

  txn_ctrl u_ctrl (
    .clk_i, .rst_ni, .begin_i, .end_i, .conflict_i(conflict),
    .active_o(active), .begin_fire_o(begin_fire), .abort_fire_o(abort_fire),
    .commit_fire_o(commit_fire), .clr_o(clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_o       <= 1'b0;
      commit_o      <= 1'b0;
      inval_mask_o  <= '0;
      commit_wset_o <= '0;
    end else begin
      abort_o       <= abort_fire;
      commit_o      <= commit_fire;
      inval_mask_o  <= abort_fire  ? wset_next : '0;
      commit_wset_o <= commit_fire ? wset_next : '0;
    end
  end

  assign active_o = active;

  logic unused_q;
  assign unused_q = begin_fire ^ (|rset_q) ^ (|wset_q);
endmodule

// File: rtl/txn_set_tracker_chk.sv
module txn_set_tracker_chk #(
  parameter int NUM_LINES = 64
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 begin_i,
  input logic                 remote_valid_i,
  input logic                 active_o,
  input logic                 abort_o,
  input logic [NUM_LINES-1:0] inval_mask_o,
  input logic                 commit_o,
  input logic [NUM_LINES-1:0] commit_wset_o
);
  // R2
  begin_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(begin_i));
  // R4
  no_early_wset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |-> (commit_wset_o == '0));
  // R5
  abort_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(remote_valid_i));
  // R8
  abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  // R8
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !active_o);
  // R8
  inval_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_o |-> (inval_mask_o == '0));
  // R9
  commit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  // R12
  abort_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abort_o && commit_o));
endmodule

bind txn_set_tracker txn_set_tracker_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i, .rst_ni, .begin_i, .remote_valid_i, .active_o, .abort_o,
  .inval_mask_o, .commit_o, .commit_wset_o
);

// File: tb/txn_set_tracker_bench.sv
`timescale 1ns/1ps
module txn_set_tracker_bench;
  localparam int N  = 64;
  localparam int IW = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic begin_i, end_i, rd_valid_i, wr_valid_i, remote_valid_i;
  logic [IW-1:0] rd_idx_i, wr_idx_i;
  logic [N-1:0]  remote_wset_i, inval_mask_o, commit_wset_o;
  logic active_o, abort_o, commit_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  txn_set_tracker #(.NUM_LINES(N)) u_txn_set_tracker (.*);

  function automatic logic [N-1:0] bit_of(int i);
    return N'(1) << i;
  endfunction

  task automatic chk(logic [N-1:0] act, logic [N-1:0] exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet();
    begin_i = 0; end_i = 0; rd_valid_i = 0; wr_valid_i = 0;
    remote_valid_i = 0; rd_idx_i = '0; wr_idx_i = '0; remote_wset_i = '0;
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
    quiet();
  endtask

  task automatic do_begin();
    begin_i = 1; cyc();
  endtask

  task automatic do_wr(int i);
    wr_valid_i = 1; wr_idx_i = IW'(i); cyc();
  endtask

  task automatic do_rd(int i);
    rd_valid_i = 1; rd_idx_i = IW'(i); cyc();
  endtask

  task automatic t_reset();
    chk(N'(active_o), 0, "R1 active");
    chk(N'(abort_o), 0, "R1 abort");
    chk(N'(commit_o), 0, "R1 commit");
    chk(commit_wset_o, 0, "R1 wset");
    chk(inval_mask_o, 0, "R1 inval");
  endtask

  task automatic t_begin_empty();
    do_begin();
    chk(N'(active_o), 1, "R2 active after begin");
    end_i = 1; cyc();
    chk(N'(commit_o), 1, "R9 commit pulse");
    chk(commit_wset_o, 0, "R2 empty set");
    cyc();
    chk(N'(commit_o), 0, "R9 one cycle");
    chk(N'(active_o), 0, "R9 idle after");
  endtask

  task automatic t_write_commit();
    do_begin();
    do_wr(3);
    do_wr(63);
    chk(commit_wset_o, 0, "R4 no leak while active");
    end_i = 1; wr_valid_i = 1; wr_idx_i = 6'd10; cyc();
    chk(N'(commit_o), 1, "R9 commit");
    chk(commit_wset_o, bit_of(3) | bit_of(10) | bit_of(63), "R3 write set");
    cyc();
    chk(commit_wset_o, 0, "R4 cleared after pulse");
  endtask

  task automatic t_read_conflict();
    do_begin();
    do_rd(5);
    do_wr(7);
    remote_valid_i = 1; remote_wset_i = bit_of(5) | bit_of(20);
    wr_valid_i = 1; wr_idx_i = 6'd0; cyc();
    chk(N'(abort_o), 1, "R5 abort on read overlap");
    chk(inval_mask_o, bit_of(7) | bit_of(0), "R8 inval mask");
    chk(N'(active_o), 0, "R8 idle on abort");
    cyc();
    chk(N'(abort_o), 0, "R8 one cycle");
    chk(inval_mask_o, 0, "R8 mask quiet");
    // retry
    do_begin();
    do_wr(2);
    end_i = 1; cyc();
    chk(commit_wset_o, bit_of(2), "R8 retry commit");
    cyc();
  endtask

  task automatic t_write_only();
    do_begin();
    do_wr(9);
    remote_valid_i = 1; remote_wset_i = bit_of(9); cyc();
    chk(N'(abort_o), 0, "R6 no abort on write overlap");
    chk(N'(active_o), 1, "R6 still active");
    end_i = 1; cyc();
    chk(commit_wset_o, bit_of(9), "R6 commit after");
    cyc();
  endtask

  task automatic t_same_cycle();
    do_begin();
    rd_valid_i = 1; rd_idx_i = 6'd12;
    remote_valid_i = 1; remote_wset_i = bit_of(12); cyc();
    chk(N'(abort_o), 1, "R7 same-cycle read");
    cyc();
  endtask

  task automatic t_clear();
    do_begin();
    do_rd(30);
    do_wr(31);
    end_i = 1; cyc();
    cyc();
    do_begin();
    remote_valid_i = 1; remote_wset_i = bit_of(30); cyc();
    chk(N'(abort_o), 0, "R10 stale read gone");
    end_i = 1; cyc();
    chk(commit_wset_o, 0, "R10 stale write gone");
    cyc();
  endtask

  task automatic t_idle_ignore();
    wr_valid_i = 1; wr_idx_i = 6'd4; rd_valid_i = 1; rd_idx_i = 6'd4;
    remote_valid_i = 1; remote_wset_i = bit_of(4); end_i = 1; cyc();
    chk(N'(abort_o), 0, "R11 abort");
    chk(N'(commit_o), 0, "R11 commit");
    chk(N'(active_o), 0, "R11 active");
    do_begin();
    remote_valid_i = 1; remote_wset_i = bit_of(4); cyc();
    chk(N'(abort_o), 0, "R11 idle read ignored");
    end_i = 1; cyc();
    chk(commit_wset_o, 0, "R11 idle write ignored");
    cyc();
  endtask

  task automatic t_priority();
    do_begin();
    do_rd(1);
    end_i = 1; remote_valid_i = 1; remote_wset_i = bit_of(1); cyc();
    chk(N'(abort_o), 1, "R12 abort wins");
    chk(N'(commit_o), 0, "R12 no commit");
    cyc();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    quiet();
    #25 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_begin_empty();
    t_write_commit();
    t_read_conflict();
    t_write_only();
    t_same_cycle();
    t_clear();
    t_idle_ignore();
    t_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule